// File: doc/BRIEF.md
# Byte-wide arithmetic and logic unit with registered condition flags

This block computes an 8-bit result from one or two operands and a 5-bit operation code in the same cycle, and holds six condition flags in a status register that updates on the clock edge when the write enable is high. It covers addition and subtraction, each with an optional incoming carry or borrow. It covers compares that set flags without producing a result to write back. It covers bitwise AND, OR and XOR. On a single operand it can complement, negate, swap nibbles, increment, decrement, shift arithmetic right, shift logical right and rotate right through the carry.

A surrounding datapath feeds the two operands and the carry input, takes `result` into its register file when `wb_valid` is high, and reads the flag byte from `status`. Flags the current operation does not define keep their stored values, so chains of operations can pass carry and zero from one byte to the next.

Top module: `alu8_status`

## Requirements
- R1: A synchronous active-low reset clears `status` to 0x00. In the status byte, bit 0 is carry C, bit 1 is zero Z, bit 2 is negative N, bit 3 is overflow V, bit 4 is sign S, bit 5 is half-carry H, and bits 7:6 always read 0.
- R2: ADD (00000) and ADC (00001) give `result` = A+B (+`cin` for ADC only) modulo 256. C is the carry out of bit 7, H is the carry out of bit 3, and V is set on two's-complement overflow.
- R3: SUB (00011) and SBC (00010) give `result` = A−B (−`cin` for SBC only) modulo 256. C is set when a borrow leaves bit 7, H is set on a borrow into bit 4, and V is set on signed overflow.
- R4: CP (00101) and CPC (00100) set the flags exactly as SUB and SBC do, and `wb_valid` stays low.
- R5: For SBC and CPC, Z is cleared when the result is nonzero. When the result is zero, Z keeps its stored value.
- R6: Every flag-writing operation sets N to result bit 7 and S to N XOR V. Z is set when the result is zero, except in the case given by R5.
- R7: AND (00110), OR (00111) and XOR (01000) clear V and leave C and H unchanged.
- R8: COM (10000) gives the bitwise inverse, sets C and clears V. NEG (10001) gives 0−A, with C = (result≠0), H = (A bits 3:0 ≠ 0) and V = (result = 0x80).
- R9: SWAP (10010) exchanges the two nibbles of A and leaves every flag unchanged.
- R10: INC (10011) and DEC (11010) change neither C nor H. V is set when INC starts from 0x7F and when DEC starts from 0x80.
- R11: ASR (10101), LSR (10110) and ROR (10111) shift A right by one. The new bit 7 is A[7] for ASR, 0 for LSR and `cin` for ROR. C takes A[0], and V = N XOR C.
- R12: When `we` is low, `status` keeps its value and `wb_valid` is low. Codes not listed here give `result` 0 and no writeback, and leave the flags unchanged.
- R13: `wb_valid` is high exactly when `we` is high and the code is a listed operation other than CP or CPC. Operand B is ignored by single-operand codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| we | input | 1 | Commit flags and allow writeback this cycle |
| op | input | 5 | Operation code |
| opa | input | 8 | First operand, or the only operand of single-operand codes |
| opb | input | 8 | Second operand |
| cin | input | 1 | Incoming carry or borrow for ADC, SBC, CPC and ROR |
| result | output | 8 | Combinational result |
| wb_valid | output | 1 | Result is to be written back |
| status | output | 8 | Registered flag byte |

## Verification
The bench targets the carry and borrow edges. It checks 0xFF+1 wrapping to zero with C set. It checks 0x10−1, which has to show a half borrow. A design that used the raw adder carry on subtracts would invert C and H there. It checks 0x7F+1 and 0x80−1, where an overflow formula taken from the wrong operand would miss V.

A multi-byte compare sequence shows whether CPC sets Z on a zero high byte when the low bytes differed. A wrong design would report equality there. Chained with the low bytes equal, it shows whether CPC keeps Z.

Logic, INC, DEC and SWAP run after C and H have been set. A design that cleared those flags would show the change in `status`. Shifts of odd operands and NEG of 0 and 0x80 check the carry and overflow special cases. A random mix checks the flags against a model computed from the requirements.

// File: rtl/alu8_pkg.sv
// Shared operation codes and flag positions for the byte ALU.
// Assumes an 8-bit status byte with bits 7:6 unused.
package alu8_pkg;
    localparam int FLG_C = 0;
    localparam int FLG_Z = 1;
    localparam int FLG_N = 2;
    localparam int FLG_V = 3;
    localparam int FLG_S = 4;
    localparam int FLG_H = 5;
    localparam int SR_W  = 8;

    // Two-operand codes: bits 3:1 pick the class, bit 0 is the chain bit
    // (set = chained for add, clear = chained for subtract/compare).
    localparam logic [4:0] OP_ADD  = 5'b00000;
    localparam logic [4:0] OP_ADC  = 5'b00001;
    localparam logic [4:0] OP_SBC  = 5'b00010;
    localparam logic [4:0] OP_SUB  = 5'b00011;
    localparam logic [4:0] OP_CPC  = 5'b00100;
    localparam logic [4:0] OP_CP   = 5'b00101;
    localparam logic [4:0] OP_AND  = 5'b00110;
    localparam logic [4:0] OP_OR   = 5'b00111;
    localparam logic [4:0] OP_XOR  = 5'b01000;
    // Single-operand codes: 10 plus a 3-bit function field; DEC sits apart.
    localparam logic [4:0] OP_COM  = 5'b10000;
    localparam logic [4:0] OP_NEG  = 5'b10001;
    localparam logic [4:0] OP_SWAP = 5'b10010;
    localparam logic [4:0] OP_INC  = 5'b10011;
    localparam logic [4:0] OP_ASR  = 5'b10101;
    localparam logic [4:0] OP_LSR  = 5'b10110;
    localparam logic [4:0] OP_ROR  = 5'b10111;
    localparam logic [4:0] OP_DEC  = 5'b11010;
endpackage

// File: rtl/alu8_addsub.sv
// Shared adder for add, subtract, negate, increment and decrement.
// In subtract mode y is inverted and cin acts as a borrow; the C and H
// outputs then report borrows instead of carries. Purely combinational.
module alu8_addsub #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] y,
    input  logic          sub,
    input  logic          ci,
    output logic [DW-1:0] sum,
    output logic          c_flag,
    output logic          h_flag,
    output logic          v_flag
);
    localparam int HW = DW / 2;

    logic [DW-1:0] y_eff;
    logic          c0;
    logic [HW:0]   lo;
    logic [DW-HW:0] hi;

    // Split the sum at the nibble boundary to expose the half carry.
    always_comb begin
        y_eff  = sub ? ~y : y;
        c0     = sub ? ~ci : ci;
        lo     = {1'b0, x[HW-1:0]} + {1'b0, y_eff[HW-1:0]} + {{HW{1'b0}}, c0};
        hi     = {1'b0, x[DW-1:HW]} + {1'b0, y_eff[DW-1:HW]} + {{(DW-HW){1'b0}}, lo[HW]};
        sum    = {hi[DW-HW-1:0], lo[HW-1:0]};
        c_flag = sub ? ~hi[DW-HW] : hi[DW-HW];
        h_flag = sub ? ~lo[HW] : lo[HW];
        v_flag = (x[DW-1] == y_eff[DW-1]) && (sum[DW-1] != x[DW-1]);
    end
endmodule

// File: rtl/alu8_bitops.sv
// Non-arithmetic results: AND/OR/XOR, complement, nibble swap, right shifts.
// Codes it does not own yield zero; the top selects between units.
module alu8_bitops
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [4:0]    op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          ci,
    output logic [DW-1:0] res
);
    localparam int HW = DW / 2;

    // Select the bitwise or shift result for the current code.
    always_comb begin
        unique case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_COM:  res = ~a;
            OP_SWAP: res = {a[HW-1:0], a[DW-1:HW]};
            OP_ASR:  res = {a[DW-1], a[DW-1:1]};
            OP_LSR:  res = {1'b0, a[DW-1:1]};
            OP_ROR:  res = {ci, a[DW-1:1]};
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/alu8_status.sv
// Byte ALU top: routes operands to the adder or bit unit, forms the next
// flag byte per operation class and registers it when we is high.
// Assumes the caller supplies the carry/borrow input on cin.
module alu8_status
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [4:0]    op,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  logic          cin,
    output logic [DW-1:0] result,
    output logic          wb_valid,
    output logic [SR_W-1:0] status
);
    logic [DW-1:0]   ax, ay, asum, bres;
    logic            asub, aci, ac, ah, av;
    logic [SR_W-1:0] status_q, status_d;
    logic            wr_res, is_cmp, chain_sub;
    logic            rz, rn;

    // Pick adder operands for the arithmetic codes.
    always_comb begin
        ax = opa; ay = opb; asub = 1'b0; aci = 1'b0;
        chain_sub = (op == OP_SBC) || (op == OP_CPC);
        unique case (op)
            OP_ADD, OP_ADC:                 aci = op[0] & cin;
            OP_SUB, OP_SBC, OP_CP, OP_CPC: begin asub = 1'b1; aci = ~op[0] & cin; end
            OP_NEG:  begin ax = '0; ay = opa; asub = 1'b1; end
            OP_INC:  ay = DW'(1);
            OP_DEC:  begin ay = DW'(1); asub = 1'b1; end
            default: ;
        endcase
    end

    alu8_addsub #(.DW(DW)) u_addsub (
        .x(ax), .y(ay), .sub(asub), .ci(aci),
        .sum(asum), .c_flag(ac), .h_flag(ah), .v_flag(av)
    );

    alu8_bitops #(.DW(DW)) u_bitops (
        .op(op), .a(opa), .b(opb), .ci(cin), .res(bres)
    );

    // Choose the result and build the next flag byte by operation class.
    always_comb begin
        status_d = status_q;
        wr_res   = 1'b0;
        is_cmp   = 1'b0;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CP, OP_CPC, OP_NEG,
            OP_INC, OP_DEC: result = asum;
            default:        result = bres;
        endcase
        rz = (result == '0);
        rn = result[DW-1];
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CP, OP_CPC, OP_NEG: begin
                is_cmp = (op == OP_CP) || (op == OP_CPC);
                wr_res = !is_cmp;
                status_d[FLG_C] = ac;
                status_d[FLG_H] = ah;
                status_d[FLG_V] = av;
                status_d[FLG_Z] = chain_sub ? (rz & status_q[FLG_Z]) : rz;
            end
            OP_AND, OP_OR, OP_XOR: begin
                wr_res = 1'b1;
                status_d[FLG_V] = 1'b0;
                status_d[FLG_Z] = rz;
            end
            OP_COM: begin
                wr_res = 1'b1;
                status_d[FLG_C] = 1'b1;
                status_d[FLG_V] = 1'b0;
                status_d[FLG_Z] = rz;
            end
            OP_INC, OP_DEC: begin
                wr_res = 1'b1;
                status_d[FLG_V] = av;
                status_d[FLG_Z] = rz;
            end
            OP_ASR, OP_LSR, OP_ROR: begin
                wr_res = 1'b1;
                status_d[FLG_C] = opa[0];
                status_d[FLG_V] = rn ^ opa[0];
                status_d[FLG_Z] = rz;
            end
            OP_SWAP: wr_res = 1'b1;
            default: ;
        endcase
        if (wr_res || is_cmp) begin
            if (op != OP_SWAP) begin
                status_d[FLG_N] = rn;
                status_d[FLG_S] = rn ^ status_d[FLG_V];
            end
        end
        status_d[SR_W-1:6] = '0;
    end

    // Flag register: cleared by reset, committed only under we.
    always_ff @(posedge clk) begin
        if (!rst_n)  status_q <= '0;
        else if (we) status_q <= status_d;
    end

    assign status   = status_q;
    assign wb_valid = we & wr_res;

    // R1
    reset_clears_chk: assert property (@(posedge clk) !rst_n |=> status_q == '0);

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(status_q));

    // R5
    chain_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (op == OP_SBC || op == OP_CPC) && result != '0) |=> !status_q[FLG_Z]);

    // R7
    logic_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (op == OP_AND || op == OP_OR || op == OP_XOR))
        |=> status_q[FLG_C] == $past(status_q[FLG_C]));

    // R8
    com_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && op == OP_COM) |=> status_q[FLG_C]);

    // R4
    always_comb begin
        if (op == OP_CP || op == OP_CPC)
            cmp_no_wb_chk: assert (!wb_valid);
    end
endmodule

// File: tb/alu8_status_tb.sv
module alu8_status_tb;
    import alu8_pkg::*;

    typedef struct {
        logic [7:0] res;
        logic       wb;
        logic [7:0] sr;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       we = 1'b0;
    logic [4:0] op = OP_ADD;
    logic [7:0] opa = '0, opb = '0;
    logic       cin = 1'b0;
    logic [7:0] result, status;
    logic       wb_valid;

    int checks = 0, errors = 0;
    exp_t q[$];
    logic [7:0] sr_m = '0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    alu8_status u_dut (
        .clk(clk), .rst_n(rst_n), .we(we), .op(op), .opa(opa), .opb(opb),
        .cin(cin), .result(result), .wb_valid(wb_valid), .status(status)
    );

    // Reference model written from the requirements.
    function automatic exp_t model(input logic [4:0] o, input logic [7:0] a, b,
                                   input logic ci, input logic w, input logic [7:0] sr);
        exp_t e;
        int r, k;
        logic c, z, v, h, n, known, chained;
        c = sr[0]; z = sr[1]; v = sr[3]; h = sr[5];
        e.res = '0; e.wb = 1'b0; known = 1'b1; chained = 1'b0;
        case (o)
            OP_ADD, OP_ADC: begin
                k = (o == OP_ADC) ? int'(ci) : 0;
                r = int'(a) + int'(b) + k; e.res = r[7:0]; c = r > 255;
                h = (int'(a % 16) + int'(b % 16) + k) > 15;
                v = (a[7] == b[7]) && (e.res[7] != a[7]); e.wb = 1'b1;
            end
            OP_SUB, OP_SBC, OP_CP, OP_CPC: begin
                chained = (o == OP_SBC) || (o == OP_CPC);
                k = chained ? int'(ci) : 0;
                r = int'(a) - int'(b) - k; e.res = r[7:0]; c = r < 0;
                h = int'(a % 16) < int'(b % 16) + k;
                v = (a[7] != b[7]) && (e.res[7] != a[7]);
                e.wb = (o == OP_SUB) || (o == OP_SBC);
            end
            OP_AND: begin e.res = a & b; v = 1'b0; e.wb = 1'b1; end
            OP_OR:  begin e.res = a | b; v = 1'b0; e.wb = 1'b1; end
            OP_XOR: begin e.res = a ^ b; v = 1'b0; e.wb = 1'b1; end
            OP_COM: begin e.res = ~a; c = 1'b1; v = 1'b0; e.wb = 1'b1; end
            OP_NEG: begin
                e.res = 8'(0 - int'(a)); c = a != 0; h = (a % 16) != 0;
                v = a == 8'h80; e.wb = 1'b1;
            end
            OP_SWAP: begin e.res = {a[3:0], a[7:4]}; e.wb = 1'b1; end
            OP_INC: begin e.res = a + 8'd1; v = a == 8'h7F; e.wb = 1'b1; end
            OP_DEC: begin e.res = a - 8'd1; v = a == 8'h80; e.wb = 1'b1; end
            OP_ASR, OP_LSR, OP_ROR: begin
                e.res = {(o == OP_ASR) ? a[7] : (o == OP_ROR) ? ci : 1'b0, a[7:1]};
                c = a[0]; v = e.res[7] ^ a[0]; e.wb = 1'b1;
            end
            default: known = 1'b0;
        endcase
        e.sr = sr;
        if (known && o != OP_SWAP) begin
            n = e.res[7];
            z = chained ? ((e.res == 0) && sr[1]) : (e.res == 0);
            e.sr = {2'b00, h, n ^ v, v, n, z, c};
        end
        if (!w) begin e.wb = 1'b0; e.sr = sr; end
        return e;
    endfunction

    function automatic string tag_of(input logic [4:0] o);
        case (o)
            OP_ADD, OP_ADC:         return "R2";
            OP_SUB, OP_SBC:         return "R3";
            OP_CP, OP_CPC:          return "R4";
            OP_AND, OP_OR, OP_XOR:  return "R7";
            OP_COM, OP_NEG:         return "R8";
            OP_SWAP:                return "R9";
            OP_INC, OP_DEC:         return "R10";
            OP_ASR, OP_LSR, OP_ROR: return "R11";
            default:                return "R12";
        endcase
    endfunction

    // Driver: apply one operation at the falling edge and queue its expectation.
    task automatic drive(input logic [4:0] o, input logic [7:0] a, b,
                         input logic ci, input logic w, input string tag);
        exp_t e;
        @(negedge clk);
        op = o; opa = a; opb = b; cin = ci; we = w;
        e = model(o, a, b, ci, w, sr_m);
        e.tag = tag;
        q.push_back(e);
        sr_m = e.sr;
    endtask

    // Monitor: after each rising edge compare outputs against the queue head.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (result !== e.res || wb_valid !== e.wb || status !== e.sr) begin
                    errors++;
                    $display("FAIL %s: res=%h wb=%b sr=%h expected res=%h wb=%b sr=%h",
                             e.tag, result, wb_valid, status, e.res, e.wb, e.sr);
                end
            end
        end
    end

    task automatic check_reset(input string tag);
        checks++;
        if (status !== 8'h00) begin
            errors++;
            $display("FAIL %s: status=%h expected 00", tag, status);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1 check_reset("R1");
        drive(OP_ADD, 8'h0F, 8'h01, 1'b0, 1'b1, "R2");
        drive(OP_ADD, 8'h7F, 8'h01, 1'b0, 1'b1, "R2");
        drive(OP_ADD, 8'hFF, 8'h01, 1'b0, 1'b1, "R2");
        drive(OP_ADC, 8'h10, 8'h20, 1'b1, 1'b1, "R2");
        drive(OP_ADD, 8'h10, 8'h20, 1'b1, 1'b1, "R2");
        drive(OP_SUB, 8'h10, 8'h01, 1'b0, 1'b1, "R3");
        drive(OP_SUB, 8'h01, 8'h02, 1'b0, 1'b1, "R3");
        drive(OP_SUB, 8'h80, 8'h01, 1'b1, 1'b1, "R3");
        drive(OP_SBC, 8'h05, 8'h05, 1'b1, 1'b1, "R3");
        drive(OP_CP,  8'h12, 8'h12, 1'b0, 1'b1, "R4");
        drive(OP_CPC, 8'h34, 8'h34, 1'b0, 1'b1, "R5");
        drive(OP_CP,  8'h12, 8'h13, 1'b0, 1'b1, "R4");
        drive(OP_CPC, 8'h34, 8'h33, 1'b1, 1'b1, "R5");
        drive(OP_CPC, 8'h50, 8'h51, 1'b0, 1'b1, "R5");
        drive(OP_SBC, 8'h00, 8'h00, 1'b0, 1'b1, "R5");
        drive(OP_ADD, 8'h08, 8'hF8, 1'b0, 1'b1, "R6");
        drive(OP_AND, 8'hF0, 8'h0F, 1'b0, 1'b1, "R7");
        drive(OP_OR,  8'h80, 8'h01, 1'b0, 1'b1, "R7");
        drive(OP_XOR, 8'hAA, 8'hAA, 1'b0, 1'b1, "R7");
        drive(OP_COM, 8'h00, 8'h55, 1'b0, 1'b1, "R8");
        drive(OP_NEG, 8'h00, 8'h00, 1'b0, 1'b1, "R8");
        drive(OP_NEG, 8'h80, 8'h00, 1'b0, 1'b1, "R8");
        drive(OP_NEG, 8'h01, 8'h00, 1'b0, 1'b1, "R8");
        drive(OP_SWAP, 8'h3C, 8'hFF, 1'b1, 1'b1, "R9");
        drive(OP_ADD, 8'h0F, 8'hF1, 1'b0, 1'b1, "R10");
        drive(OP_INC, 8'h7F, 8'h00, 1'b0, 1'b1, "R10");
        drive(OP_DEC, 8'h80, 8'h00, 1'b0, 1'b1, "R10");
        drive(OP_INC, 8'hFF, 8'h00, 1'b0, 1'b1, "R10");
        drive(OP_ASR, 8'h81, 8'h00, 1'b0, 1'b1, "R11");
        drive(OP_LSR, 8'h01, 8'h00, 1'b0, 1'b1, "R11");
        drive(OP_ROR, 8'h02, 8'h00, 1'b1, 1'b1, "R11");
        drive(OP_ADD, 8'hFF, 8'hFF, 1'b0, 1'b0, "R12");
        drive(5'b10100, 8'h00, 8'h00, 1'b1, 1'b1, "R12");
        drive(5'b01111, 8'h12, 8'h34, 1'b0, 1'b1, "R12");
        drive(OP_CP, 8'h00, 8'h00, 1'b0, 1'b0, "R13");
        drive(OP_INC, 8'h10, 8'hAA, 1'b0, 1'b1, "R13");
        for (int i = 0; i < 400; i++) begin
            logic [4:0] o;
            logic [4:0] codes[17];
            codes = '{OP_ADD, OP_ADC, OP_SBC, OP_SUB, OP_CPC, OP_CP, OP_AND,
                      OP_OR, OP_XOR, OP_COM, OP_NEG, OP_SWAP, OP_INC, OP_ASR,
                      OP_LSR, OP_ROR, OP_DEC};
            o = codes[$urandom_range(0, 16)];
            drive(o, 8'($urandom), 8'($urandom), 1'($urandom), ($urandom_range(0, 7) != 0),
                  tag_of(o));
        end
        @(negedge clk); we = 1'b0; rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; sr_m = '0;
        #1 check_reset("R1");
        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule